// File: doc/BRIEF.md
# Single-Step Trap Entry Sequencer

This block sits next to a small 16-bit processor core and owns the processor's flags word. At every instruction boundary it decides whether to take a single-step trap. The decision uses the trap bit as it stood before the retiring instruction. When a trap is taken, the block stalls the core and drives a memory write port to push three return words onto the stack. It then clears the trap and interrupt-enable bits and reads the new instruction pointer and code segment from the step vector slots. Finally it hands the core a one-cycle load of the new program counter and stack pointer.

The core reports each retired instruction with a kind code and, where relevant, a flags image. The image comes from the ALU for status updates and from the stack for flags-pop and interrupt-return. While the sequencer is busy the core must not retire anything. The handler therefore runs without stepping. An interrupt return that brings the trap bit back lets exactly one instruction of the interrupted program run before the next trap.

Top module: `step_trap_seq`

## Requirements
- R1: While reset is held, `flags` is 0x0000 and `busy`, `mem_req` and `pc_load` are low.
- R2: A retire with kind 1 (status update) copies only bits 11, 7, 6, 4, 2 and 0 of `retire_image` into `flags`. Bits 10, 9 and 8 keep their values.
- R3: A retire with kind 2 (flags-pop) or kind 3 (interrupt return) loads `flags` from `retire_image` masked with 0x0FD5, so undefined bits read 0. Kind 0 leaves `flags` unchanged.
- R4: A trap starts when an instruction retires while bit 8 of `flags` was already set. A flags-pop or interrupt return that sets bit 8 from clear does not itself trap.
- R5: The entry sequence makes three 16-bit writes: first the flags after the retiring instruction's update, then `cs_cur`, then `ip_next`. They go to SP-2, SP-4 and SP-6, where SP is `sp_cur` at the trapping retire.
- R6: Once the flags write is accepted, bits 8 and 9 of `flags` are cleared and the other bits are kept.
- R7: After the pushes the block reads address 0x0004 (new IP) and then 0x0006 (new CS), which is the trap type 1 times four.
- R8: The sequence ends with one cycle of `pc_load`. In that cycle `pc_ip` and `pc_cs` hold the two vector words and `sp_new` holds SP-6. `busy` falls in the next cycle.
- R9: `busy` is high from the cycle after a trapping retire through the `pc_load` cycle. A memory request is issued only while busy and holds its address and direction until `mem_ack`.
- R10: After an interrupt return that sets bit 8 from clear, the next retired instruction traps.
- R11: A retire while bit 8 of `flags` is clear never starts a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_kind | input | 2 | 0 plain, 1 status update, 2 flags-pop, 3 interrupt return |
| retire_image | input | 16 | Flags image for kinds 1 to 3 |
| ip_next | input | 16 | Address of the next instruction |
| cs_cur | input | 16 | Current code segment |
| sp_cur | input | 16 | Stack pointer after the retiring instruction |
| mem_ack | input | 1 | Memory accepts the current request |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| busy | output | 1 | Entry sequence in progress, core stalls |
| flags | output | 16 | Current flags word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| pc_load | output | 1 | One-cycle load of new IP, CS and SP |
| pc_ip | output | 16 | New instruction pointer |
| pc_cs | output | 16 | New code segment |
| sp_new | output | 16 | Stack pointer after the pushes |

## Verification
A fixed program first covers these cases: a flags-pop that sets the trap bit, a plain retire that then traps, a status update under trap mode, an interrupt return that re-arms stepping, and a flags-pop that clears the bit on the trapping instruction itself. Each case separates the pre-instruction trap decision from a post-instruction one, and the pushed flags from the cleared ones. A stretch of random retire kinds and images with random memory latency follows. It shows whether the request holds steady under wait states and whether the masking of each kind is right for arbitrary bit patterns. A behavioural model predicts `flags`, `busy`, every bus operation and the final load on each cycle.

// File: rtl/step_trap_pkg.sv
package step_trap_pkg;
  localparam int FW = 16;

  localparam int FB_CARRY = 0;
  localparam int FB_PAR   = 2;
  localparam int FB_AUX   = 4;
  localparam int FB_ZERO  = 6;
  localparam int FB_SIGN  = 7;
  localparam int FB_TRAP  = 8;
  localparam int FB_IEN   = 9;
  localparam int FB_DIR   = 10;
  localparam int FB_OVF   = 11;

  localparam logic [FW-1:0] STAT_MASK = FW'((1 << FB_CARRY) | (1 << FB_PAR) | (1 << FB_AUX)
                                           | (1 << FB_ZERO) | (1 << FB_SIGN) | (1 << FB_OVF));
  localparam logic [FW-1:0] CTRL_MASK = FW'((1 << FB_TRAP) | (1 << FB_IEN) | (1 << FB_DIR));
  localparam logic [FW-1:0] DEF_MASK  = STAT_MASK | CTRL_MASK;

  typedef enum logic [1:0] {
    RK_PLAIN  = 2'd0,
    RK_STATUS = 2'd1,
    RK_POPF   = 2'd2,
    RK_IRET   = 2'd3
  } ret_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PUSH_F, SQ_PUSH_CS, SQ_PUSH_IP, SQ_VEC_IP, SQ_VEC_CS, SQ_LOAD
  } seq_e;
endpackage

// File: rtl/step_flags.sv
module step_flags
  import step_trap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [1:0]    upd_kind,
  input  logic [FW-1:0] upd_image,
  input  logic          clr_ti,
  output logic [FW-1:0] flags_q
);
  logic [FW-1:0] flags_d;
  logic          flags_en;

  always_comb begin
    flags_d  = flags_q;
    flags_en = 1'b0;
    if (clr_ti) begin
      flags_en         = 1'b1;
      flags_d[FB_TRAP] = 1'b0;
      flags_d[FB_IEN]  = 1'b0;
    end else if (upd_en) begin
      case (upd_kind)
        RK_STATUS: begin
          flags_en = 1'b1;
          flags_d  = (flags_q & ~STAT_MASK) | (upd_image & STAT_MASK);
        end
        RK_POPF, RK_IRET: begin
          flags_en = 1'b1;
          flags_d  = upd_image & DEF_MASK;
        end
        default: flags_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  AST_TI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ti |=> (!flags_q[FB_TRAP] && !flags_q[FB_IEN])); // R6
  AST_STATUS_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_kind == RK_STATUS && !clr_ti) |=> (flags_q[FB_DIR:FB_TRAP] == $past(flags_q[FB_DIR:FB_TRAP]))); // R2
endmodule

// File: rtl/step_entry_fsm.sv
module step_entry_fsm
  import step_trap_pkg::*;
#(
  parameter int DW        = 16,
  parameter int TRAP_TYPE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] ip_in,
  input  logic [DW-1:0] cs_in,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] flags_in,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          clr_ti,
  output logic          pc_load,
  output logic [DW-1:0] pc_ip,
  output logic [DW-1:0] pc_cs,
  output logic [DW-1:0] sp_new
);
  localparam int            WORD_BYTES = 2;
  localparam logic [DW-1:0] VEC_IP_ADDR = DW'(TRAP_TYPE * 2 * WORD_BYTES);
  localparam logic [DW-1:0] VEC_CS_ADDR = VEC_IP_ADDR + DW'(WORD_BYTES);
  localparam logic [DW-1:0] STEP        = DW'(WORD_BYTES);

  seq_e          state_q, state_d;
  logic [DW-1:0] ip_q, cs_q, sp_q, vip_q, vcs_q;
  logic          cap_en, push_ack, vip_en, vcs_en;

  always_comb begin
    state_d   = state_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    clr_ti    = 1'b0;
    case (state_q)
      SQ_IDLE: if (start) state_d = SQ_PUSH_F;
      SQ_PUSH_F: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_q - STEP; mem_wdata = flags_in;
        if (mem_ack) begin clr_ti = 1'b1; state_d = SQ_PUSH_CS; end
      end
      SQ_PUSH_CS: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_q - STEP; mem_wdata = cs_q;
        if (mem_ack) state_d = SQ_PUSH_IP;
      end
      SQ_PUSH_IP: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_q - STEP; mem_wdata = ip_q;
        if (mem_ack) state_d = SQ_VEC_IP;
      end
      SQ_VEC_IP: begin
        mem_req = 1'b1; mem_addr = VEC_IP_ADDR;
        if (mem_ack) state_d = SQ_VEC_CS;
      end
      SQ_VEC_CS: begin
        mem_req = 1'b1; mem_addr = VEC_CS_ADDR;
        if (mem_ack) state_d = SQ_LOAD;
      end
      SQ_LOAD: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  assign cap_en   = start && (state_q == SQ_IDLE);
  assign push_ack = mem_req && mem_we && mem_ack;
  assign vip_en   = (state_q == SQ_VEC_IP) && mem_ack;
  assign vcs_en   = (state_q == SQ_VEC_CS) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= '0; cs_q <= '0; sp_q <= '0;
    end else if (cap_en) begin
      ip_q <= ip_in; cs_q <= cs_in; sp_q <= sp_in;
    end else if (push_ack) begin
      sp_q <= sp_q - STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vip_q <= '0;
    else if (vip_en) vip_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vcs_q <= '0;
    else if (vcs_en) vcs_q <= mem_rdata;
  end

  assign busy    = (state_q != SQ_IDLE);
  assign pc_load = (state_q == SQ_LOAD);
  assign pc_ip   = vip_q;
  assign pc_cs   = vcs_q;
  assign sp_new  = sp_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_ack |=> (sp_new == $past(sp_new) - STEP)); // R5
  AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R9
endmodule

// File: rtl/step_trap_seq.sv
module step_trap_seq
  import step_trap_pkg::*;
#(
  parameter int DW        = 16,
  parameter int TRAP_TYPE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          retire_valid,
  input  logic [1:0]    retire_kind,
  input  logic [DW-1:0] retire_image,
  input  logic [DW-1:0] ip_next,
  input  logic [DW-1:0] cs_cur,
  input  logic [DW-1:0] sp_cur,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic [DW-1:0] flags,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          pc_load,
  output logic [DW-1:0] pc_ip,
  output logic [DW-1:0] pc_cs,
  output logic [DW-1:0] sp_new
);
  logic accept, take, clr_ti;

  assign accept = retire_valid && !busy;
  assign take   = accept && flags[FB_TRAP];

  step_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (accept),
    .upd_kind  (retire_kind),
    .upd_image (retire_image),
    .clr_ti    (clr_ti),
    .flags_q   (flags)
  );

  step_entry_fsm #(.DW(DW), .TRAP_TYPE(TRAP_TYPE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (take),
    .ip_in     (ip_next),
    .cs_in     (cs_cur),
    .sp_in     (sp_cur),
    .flags_in  (flags),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .clr_ti    (clr_ti),
    .pc_load   (pc_load),
    .pc_ip     (pc_ip),
    .pc_cs     (pc_cs),
    .sp_new    (sp_new)
  );

  AST_NO_TRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !flags[FB_TRAP]) |=> !busy); // R11
endmodule

// File: tb/tb_step_trap_seq.sv
module tb_step_trap_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_valid;
  logic [1:0]  retire_kind;
  logic [15:0] retire_image, ip_next, cs_cur, sp_cur, mem_rdata;
  logic        mem_ack;
  logic        busy, mem_req, mem_we, pc_load;
  logic [15:0] flags, mem_addr, mem_wdata, pc_ip, pc_cs, sp_new;

  localparam logic [15:0] VIP = 16'h1234;
  localparam logic [15:0] VCS = 16'hF000;

  always #2 clk = ~clk;

  step_trap_seq dut (.*);

  int total = 0, bad = 0;
  int q_we[$], q_addr[$], q_data[$];
  int s_kind[$], s_img[$];
  logic [15:0] exp_flags, exp_sp;
  bit exp_busy, exp_pcload;
  int traps_exp = 0, traps_seen = 0, wait_cnt = 0;
  bit last_ret, last_tpre, last_tset, arm10, check10;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] upd(logic [15:0] f, int k, logic [15:0] img);
    case (k)
      1: return (f & ~16'h08D5) | (img & 16'h08D5);
      2, 3: return img & 16'h0FD5;
      default: return f;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int kinds[11] = '{1, 0, 2, 0, 1, 3, 1, 2, 2, 3, 3};
    int imgs[11]  = '{16'hFFFF, 0, 16'hF3FF, 0, 0, 16'h0D01, 16'h0004, 16'h0100, 0, 16'h0300, 16'h0100};
    int cyc;
    foreach (kinds[i]) begin s_kind.push_back(kinds[i]); s_img.push_back(imgs[i]); end
    for (int i = 0; i < 60; i++) begin
      s_kind.push_back(int'($urandom_range(0, 3)));
      s_img.push_back(int'($urandom_range(0, 65535)));
    end
    rst_n = 1'b0; retire_valid = 0; retire_kind = 0; retire_image = 0;
    ip_next = 0; cs_cur = 0; sp_cur = 0; mem_ack = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(flags == 16'h0000, "R1", "flags in reset", flags, 0);
    chk(!busy, "R1", "busy in reset", busy, 0);
    chk(!mem_req, "R1", "mem_req in reset", mem_req, 0);
    chk(!pc_load, "R1", "pc_load in reset", pc_load, 0);
    rst_n = 1'b1;
    exp_flags = 0; exp_busy = 0; exp_pcload = 0; last_ret = 0; arm10 = 0; check10 = 0;
    cyc = 0;
    while ((s_kind.size() > 0 || exp_busy || exp_pcload) && cyc < 5000) begin
      logic [15:0] fn; bit bn, pn;
      @(negedge clk);
      cyc++;
      // compare against model state after the last edge
      chk(flags == exp_flags, "R2 R3 R6", "flags", flags, exp_flags);
      chk(busy == exp_busy, "R9", "busy", busy, exp_busy);
      chk(!mem_req || exp_busy, "R9", "request outside busy", mem_req, 0);
      chk(pc_load == exp_pcload, "R8", "pc_load", pc_load, exp_pcload);
      if (pc_load) traps_seen++;
      if (exp_pcload) begin
        chk(pc_ip == VIP, "R7 R8", "pc_ip", pc_ip, VIP);
        chk(pc_cs == VCS, "R7 R8", "pc_cs", pc_cs, VCS);
        chk(sp_new == exp_sp, "R8", "sp_new", sp_new, exp_sp);
      end
      if (last_ret) begin
        if (last_tpre) chk(busy, "R4", "trap after retire with trap bit", busy, 1);
        else if (last_tset) chk(!busy, "R4", "trap-setting retire trapped itself", busy, 0);
        else chk(!busy, "R11", "trap without trap bit", busy, 0);
        if (check10) chk(busy, "R10", "trap after one stepped instruction", busy, 1);
      end
      last_ret = 0; check10 = 0;
      // drive the next cycle and advance the model
      fn = exp_flags; bn = exp_busy; pn = 0;
      retire_valid = 0;
      if (exp_pcload) bn = 0;
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (wait_cnt == 0) begin
          mem_ack = 1;
          mem_rdata = (mem_addr == 16'h0004) ? VIP : (mem_addr == 16'h0006) ? VCS : 16'hDEAD;
          if (q_we.size() == 0) chk(0, "R5", "unexpected request", mem_addr, 0);
          else begin
            int ew, ea, ed;
            ew = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front();
            chk(mem_we == ew[0], "R5 R7", "direction", mem_we, ew);
            chk(mem_addr == ea[15:0], "R5 R7", "address", mem_addr, ea);
            if (ew != 0) chk(mem_wdata == ed[15:0], "R5", "push data", mem_wdata, ed);
            if (q_we.size() == 4) fn = fn & ~16'h0300;
            if (q_we.size() == 0) pn = 1;
          end
          wait_cnt = int'($urandom_range(0, 2));
        end else wait_cnt--;
      end
      if (!exp_busy && s_kind.size() > 0 && $urandom_range(0, 2) != 0) begin
        int k, im;
        k = s_kind.pop_front(); im = s_img.pop_front();
        retire_valid = 1; retire_kind = 2'(k); retire_image = 16'(im);
        ip_next = 16'($urandom); cs_cur = 16'($urandom); sp_cur = 16'($urandom_range(16, 65534));
        last_ret = 1; last_tpre = exp_flags[8];
        fn = upd(exp_flags, k, 16'(im));
        last_tset = !exp_flags[8] && fn[8];
        check10 = arm10; arm10 = 0;
        if (k == 3 && last_tset) arm10 = 1;
        if (last_tpre) begin
          bn = 1; traps_exp++;
          exp_sp = sp_cur - 16'd6;
          q_we.push_back(1); q_addr.push_back(int'(sp_cur - 16'd2)); q_data.push_back(int'(fn));
          q_we.push_back(1); q_addr.push_back(int'(sp_cur - 16'd4)); q_data.push_back(int'(cs_cur));
          q_we.push_back(1); q_addr.push_back(int'(sp_cur - 16'd6)); q_data.push_back(int'(ip_next));
          q_we.push_back(0); q_addr.push_back(4); q_data.push_back(0);
          q_we.push_back(0); q_addr.push_back(6); q_data.push_back(0);
        end
      end
      exp_flags = fn; exp_busy = bn; exp_pcload = pn;
    end
    repeat (3) @(negedge clk);
    chk(traps_seen == traps_exp, "R8", "completed traps", traps_seen, traps_exp);
    chk(q_we.size() == 0, "R5", "bus operations left", q_we.size(), 0);
    chk(traps_exp >= 4, "R4", "traps exercised", traps_exp, 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule